// File: doc/BRIEF.md
# Battery-backed SRAM controller

This block is a clock-sampled model of the device side of a byte-wide, battery-backed static RAM. Three active-low controls select the mode: chip select (`ce_n`), output gate (`oe_n`) and write strobe (`we_n`). A write-protect input (`wp`) comes from an external power-fail supervisor. The block stores a byte when a write window closes. It drives the data bus only during reads, and only while the output gate is low. It models the read access latency and the short interval in which old data is held after an address change.

The bus is split into `dq_in`, `dq_out` and an enable `dq_oe`, so no tri-state port is needed. `rd_valid` marks the cycles in which `dq_out` carries stored data. Whenever `rd_valid` is low, `dq_out` reads as zero. All controls are sampled on rising edges of `clk`. The mode state machine `nvsram_mode_fsm` has five states:
- ST_IDLE: standby.
- ST_ACCESS: a read is in progress but the data is not yet valid.
- ST_VALID: read data is valid.
- ST_HOLD: the old data is still shown after an address change.
- ST_WRITE: a write window is open.

Transitions:
- Any state goes to ST_IDLE when deselected. A device is deselected when `ce_n` is high or `wp` is high.
- Any state goes to ST_WRITE when `ce_n` and `we_n` are both low and `wp` is low.
- ST_IDLE or ST_WRITE goes to ST_ACCESS when read mode is entered.
- ST_ACCESS goes to ST_VALID after ACC_CYC sampled cycles at an unchanged address. An address change restarts the count.
- ST_VALID goes to ST_HOLD on an address change.
- ST_HOLD goes to ST_ACCESS after HOLD_CYC cycles.

Top module: `nvsram_port`

## Requirements
- R1: The array holds 2**ADDR_W bytes; the full-size configuration is ADDR_W=15, which gives 32,768 bytes. A byte written to one address reads back unchanged, and writes to other addresses do not disturb it.
- R2: While `ce_n` is high the device is in standby. `dq_oe` is 0, and `we_n`, `oe_n` and `dq_in` have no effect on the stored contents.
- R3: With `ce_n` low and `we_n` high the device is in read mode. `dq_oe` is 1 one cycle after a sampled low `oe_n` and 0 one cycle after a sampled high `oe_n`.
- R4: On entry to read mode, or after an address change, `rd_valid` rises once ACC_CYC+1 edges have sampled the same address in read mode. Until then `dq_oe` may be 1 while `rd_valid` is 0.
- R5: A write window is open while `ce_n` and `we_n` are both sampled low. It opens at whichever falls last and closes at whichever rises first. The byte stored is `dq_in` at `addr` as sampled on the edge where the window is first seen closed.
- R6: A sampled low `we_n` with `ce_n` low sets `dq_oe` to 0 on the next cycle, even while `oe_n` is low.
- R7: If the address changes while data is valid, the old byte stays on `dq_out` with `rd_valid` high for HOLD_CYC cycles. `rd_valid` is then 0 until the new access completes.
- R8: While `wp` is sampled high the device behaves as deselected. `dq_oe` goes to 0 on the next cycle and no byte is stored. A window that is open when `wp` rises is abandoned without a store.
- R9: During and right after reset, `dq_oe`, `rd_valid` and `dq_out` are all 0.
- R10: `dq_out` is 8'h00 whenever `rd_valid` is 0. `rd_valid` is never 1 while `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| wp | input | 1 | Write protect / deselect from power-fail supervisor, active high |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus as seen by the device |
| dq_out | output | DATA_W | Data the device drives; zero when not valid |
| dq_oe | output | 1 | Device drives the bus |
| rd_valid | output | 1 | `dq_out` carries stored data |

## Verification
Two functions can fall on the same edge. First, the closing of a write window and the start of a read access coincide when `we_n` rises while `ce_n` stays low. The bench provokes this right after a write strobe that has disabled a live read. It judges the result by the read-back byte, which must be the value on `dq_in` in that closing cycle and not any earlier value. Second, the bench raises `wp` in the same sample in which a window is open, so that deselection and the end of the window coincide. It then confirms through a later read that the abandoned window stored nothing. A behavioural model in the bench, built on an associative array, predicts `dq_oe`, `rd_valid` and `dq_out` for every clock.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_VALID,
        ST_HOLD,
        ST_WRITE
    } mode_t;

endpackage

// File: rtl/nvsram_mode_fsm.sv
module nvsram_mode_fsm
    import nvsram_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ACC_CYC  = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_commit,
    output logic              ld_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              drive_en,
    output logic              data_ok
);

    localparam int CNT_MAX = (ACC_CYC > HOLD_CYC) ? ACC_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    mode_t             state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              oe_q;

    logic sel, wr_req, addr_moved;

    assign sel        = !ce_n && !wp;
    assign wr_req     = sel && !we_n;
    assign addr_moved = (addr != addr_q);

    // next-state and counter selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else if (wr_req) begin
            state_d = ST_WRITE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WRITE: begin
                    state_d = ST_ACCESS;
                    cnt_d   = ACC_LOAD;
                    addr_d  = addr;
                end
                ST_ACCESS: begin
                    if (addr_moved) begin
                        cnt_d  = ACC_LOAD;
                        addr_d = addr;
                    end else if (cnt_q == '0) begin
                        state_d = ST_VALID;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_VALID: begin
                    if (addr_moved) begin
                        state_d = ST_HOLD;
                        cnt_d   = HOLD_LOAD;
                        addr_d  = addr;
                    end
                end
                ST_HOLD: begin
                    addr_d = addr;
                    if (cnt_q == '0) begin
                        state_d = ST_ACCESS;
                        cnt_d   = ACC_LOAD;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            oe_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            oe_q    <= oe_n;
        end
    end

    assign ld_en     = (state_q == ST_ACCESS) && sel && !wr_req
                       && !addr_moved && (cnt_q == '0);
    assign wr_commit = (state_q == ST_WRITE) && !wp && (ce_n || we_n);
    assign rd_addr   = addr_q;

    // outputs per state
    always_comb begin
        drive_en = 1'b0;
        data_ok  = 1'b0;
        unique case (state_q)
            ST_ACCESS: drive_en = !oe_q;
            ST_VALID, ST_HOLD: begin
                drive_en = !oe_q;
                data_ok  = !oe_q;
            end
            default: begin
                drive_en = 1'b0;
                data_ok  = 1'b0;
            end
        endcase
    end

    // R5: a store always ends the write window
    a_r5_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (state_q != ST_WRITE));

    // R4: data only becomes valid by finishing an access
    a_r4_valid_from_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VALID && $past(state_q) != ST_VALID) |-> $past(state_q) == ST_ACCESS);

    // R8: nothing is stored while protected
    a_r8_no_store_protected: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !wr_commit);

endmodule

// File: rtl/nvsram_store.sv
module nvsram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (ld_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    // R7: the shown byte only changes when an access completes
    a_r7_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(rd_q));

endmodule

// File: rtl/nvsram_port.sv
module nvsram_port #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int ACC_CYC  = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rd_valid
);

    localparam logic [DATA_W-1:0] IDLE_VAL = '0;

    logic              wr_commit, ld_en, drive_en, data_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_q;

    nvsram_mode_fsm #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (ACC_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wp       (wp),
        .addr     (addr),
        .wr_commit(wr_commit),
        .ld_en    (ld_en),
        .rd_addr  (rd_addr),
        .drive_en (drive_en),
        .data_ok  (data_ok)
    );

    nvsram_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_commit),
        .wr_addr(addr),
        .wr_data(dq_in),
        .ld_en  (ld_en),
        .rd_addr(rd_addr),
        .rd_q   (rd_q)
    );

    assign dq_oe    = drive_en;
    assign rd_valid = data_ok;
    assign dq_out   = data_ok ? rd_q : IDLE_VAL;

    // R2: standby releases the bus
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dq_oe);

    // R6: a write strobe turns the drivers off
    a_r6_we_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !dq_oe);

    // R8: protection releases the bus
    a_r8_wp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wp |=> !dq_oe);

    // R10: valid data only while driving
    a_r10_valid_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> !rd_valid);

endmodule

// File: tb/nvsram_port_tb.sv
`timescale 1ns/1ps
module nvsram_port_tb;

    localparam int AW   = 11;
    localparam int ACC  = 2;
    localparam int HOLD = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe, rd_valid;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R9";

    // behavioural reference: 0 idle, 1 access, 2 valid, 3 hold, 4 write
    int         m_st = 0, m_cnt = 0, m_addr = 0;
    logic [7:0] m_q = 8'h00;
    logic       m_oe_n = 1'b1;
    logic [7:0] m_mem [int];

    always #2.5 clk = ~clk;

    nvsram_port #(.ADDR_W(AW), .DATA_W(8), .ACC_CYC(ACC), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wp(wp),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rd_valid(rd_valid)
    );

    task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic model_edge();
        bit sel;
        int nst, ncnt, naddr;
        sel   = !ce_n && !wp;
        nst   = m_st;
        ncnt  = m_cnt;
        naddr = m_addr;
        if (m_st == 4 && !wp && (ce_n || we_n)) m_mem[int'(addr)] = dq_in;
        if (!sel) nst = 0;
        else if (!we_n) nst = 4;
        else if (m_st == 0 || m_st == 4) begin
            nst = 1; ncnt = ACC - 1; naddr = int'(addr);
        end else if (m_st == 1) begin
            if (int'(addr) != m_addr) begin
                ncnt = ACC - 1; naddr = int'(addr);
            end else if (m_cnt == 0) begin
                nst = 2;
                m_q = m_mem.exists(m_addr) ? m_mem[m_addr] : 8'hxx;
            end else ncnt = m_cnt - 1;
        end else if (m_st == 2) begin
            if (int'(addr) != m_addr) begin
                nst = 3; ncnt = HOLD - 1; naddr = int'(addr);
            end
        end else begin
            naddr = int'(addr);
            if (m_cnt == 0) begin
                nst = 1; ncnt = ACC - 1;
            end else ncnt = m_cnt - 1;
        end
        m_st = nst; m_cnt = ncnt; m_addr = naddr; m_oe_n = oe_n;
    endtask

    task automatic cyc();
        logic e_oe, e_val;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e_oe  = (m_st >= 1 && m_st <= 3) && !m_oe_n;
        e_val = (m_st == 2 || m_st == 3) && !m_oe_n;
        chk(cur_req, {dq_oe, rd_valid, dq_out}, {e_oe, e_val, e_val ? m_q : 8'h00});
    endtask

    task automatic drv(bit e, bit g, bit w, bit p, int a, logic [7:0] d);
        ce_n = e; oe_n = g; we_n = w; wp = p; addr = AW'(a); dq_in = d;
        cyc();
    endtask

    task automatic expect_read(int a, logic [7:0] v, string tag);
        for (int i = 0; i < ACC + 2; i++) drv(0, 0, 1, 0, a, 8'h00);
        chk(tag, {2'b00, rd_valid, dq_out[6:0]}, {2'b00, 1'b1, v[6:0]});
        chk(tag, {2'b00, dq_out}, {2'b00, v});
        drv(1, 1, 1, 0, a, 8'h00);
    endtask

    task automatic write_byte(int a, logic [7:0] v);
        drv(0, 1, 0, 0, a, 8'hEE);
        drv(0, 1, 1, 0, a, v);
        drv(1, 1, 1, 0, a, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", {dq_oe, rd_valid, dq_out}, 10'h000);
        rst_n = 1'b1;
        cyc();
        chk("R9", {dq_oe, rd_valid, dq_out}, 10'h000);

        // R5: E falls first, W rises first; data taken on the closing cycle
        cur_req = "R5";
        drv(0, 1, 1, 0, 'h12, 8'h00);
        drv(0, 1, 0, 0, 'h12, 8'h11);
        drv(0, 1, 0, 0, 'h12, 8'h22);
        drv(0, 1, 1, 0, 'h12, 8'h5A);
        drv(1, 1, 1, 0, 'h12, 8'h00);
        // R5: W falls first, E rises first
        drv(1, 1, 0, 0, 'h34, 8'h00);
        drv(0, 1, 0, 0, 'h34, 8'h33);
        drv(1, 1, 0, 0, 'h34, 8'hC3);
        drv(1, 1, 1, 0, 'h34, 8'h00);
        expect_read('h12, 8'h5A, "R5");
        expect_read('h34, 8'hC3, "R5");

        // R1: array ends and neighbours
        cur_req = "R1";
        write_byte(0, 8'h01);
        write_byte((1 << AW) - 1, 8'hF0);
        write_byte(1, 8'h02);
        expect_read(0, 8'h01, "R1");
        expect_read((1 << AW) - 1, 8'hF0, "R1");
        expect_read('h12, 8'h5A, "R1");

        // R3: read with G high keeps the bus released
        cur_req = "R3";
        for (int i = 0; i < 5; i++) drv(0, 1, 1, 0, 'h12, 8'h00);
        chk("R3", {9'h000, dq_oe}, 10'h000);
        drv(0, 0, 1, 0, 'h12, 8'h00);
        chk("R3", {dq_oe, rd_valid, dq_out}, {2'b11, 8'h5A});

        // R7: address change shows old data, then invalid, then new data
        cur_req = "R7";
        drv(0, 0, 1, 0, 'h34, 8'h00);
        chk("R7", {dq_oe, rd_valid, dq_out}, {2'b11, 8'h5A});
        drv(0, 0, 1, 0, 'h34, 8'h00);
        chk("R10", {dq_oe, rd_valid, dq_out}, {2'b10, 8'h00});
        drv(0, 0, 1, 0, 'h34, 8'h00);
        // R4: still not valid one edge before completion
        chk("R4", {9'h000, rd_valid}, 10'h000);
        drv(0, 0, 1, 0, 'h34, 8'h00);
        chk("R7", {dq_oe, rd_valid, dq_out}, {2'b11, 8'hC3});

        // R6: W low with G low turns drivers off; closing cycle also restarts a read
        cur_req = "R6";
        drv(0, 0, 0, 0, 'h34, 8'h99);
        chk("R6", {9'h000, dq_oe}, 10'h000);
        drv(0, 0, 1, 0, 'h34, 8'h77);
        chk("R6", {dq_oe, rd_valid}, 2'b10);
        for (int i = 0; i < ACC; i++) drv(0, 0, 1, 0, 'h34, 8'h00);
        chk("R5", {dq_oe, rd_valid, dq_out}, {2'b11, 8'h77});
        drv(1, 1, 1, 0, 0, 8'h00);

        // R2: standby ignores strobes
        cur_req = "R2";
        drv(1, 0, 0, 0, 'h12, 8'hFF);
        drv(1, 0, 0, 0, 'h12, 8'hFF);
        drv(1, 0, 1, 0, 'h12, 8'hEE);
        chk("R2", {9'h000, dq_oe}, 10'h000);
        expect_read('h12, 8'h5A, "R2");

        // R8: protected writes and reads, and an abandoned window
        cur_req = "R8";
        drv(0, 0, 0, 1, 'h12, 8'h11);
        drv(0, 0, 1, 1, 'h12, 8'h22);
        chk("R8", {9'h000, dq_oe}, 10'h000);
        drv(0, 1, 0, 0, 'h12, 8'h33);
        drv(0, 1, 0, 1, 'h12, 8'h44);
        drv(0, 1, 1, 1, 'h12, 8'h55);
        drv(1, 1, 1, 0, 'h12, 8'h00);
        expect_read('h12, 8'h5A, "R8");
        for (int i = 0; i < ACC + 2; i++) drv(0, 0, 1, 0, 'h34, 8'h00);
        drv(0, 0, 1, 1, 'h34, 8'h00);
        chk("R8", {dq_oe, rd_valid, dq_out}, 10'h000);
        drv(1, 1, 1, 0, 0, 8'h00);
        expect_read('h34, 8'h77, "R8");

        report();
    end

endmodule